// File: doc/BRIEF.md
# Instruction and Interrupt Cycle Sequencer

This block is the hardwired control core of a small accumulator machine. It has a 4-bit step counter, decoded one-hot into sixteen timing states, and an opcode decoder driven by the instruction register. With these it runs every instruction through a fixed fetch, decode and operand-address phase. It holds the program counter, address, instruction and temporary registers. It also drives the memory read and write strobes and keeps the addressing-mode flag and the interrupt-pending flag.

An execution unit outside the block watches the timing and decode outputs. When it has finished an instruction it pulses `exec_done`, which sends the sequencer back to the first step. The interrupt-enable and device flags come in from outside. A request seen after the fetch phase is held pending. At the next instruction boundary the block then runs a three-step interrupt cycle in place of a fetch: it stores the current program counter at address 0 and resumes execution at address 1. A halt request stops the block until reset.

Top module: `isc_seq`

## Requirements
- R1: While reset is held and just after it, the timing output has only bit 0 set and the program counter is 0. The interrupt-pending flag, the mode flag and both memory strobes are 0.
- R2: The timing output is one-hot, with bit n set when the step counter holds n. Unless the counter is cleared or the block is halted, the counter advances by one on each clock.
- R3: With no interrupt pending, step 0 copies the program counter to the memory address. Step 1 raises the read strobe, loads the instruction register from memory and increments the program counter.
- R4: With no interrupt pending, step 2 loads the memory address from instruction bits 11..0 and the mode flag from bit 15. The decode output is one-hot, with bit k set for opcode k taken from bits 14..12.
- R5: At step 3, when the opcode is not 7 and the mode flag is 1, the read strobe is high and the memory address is reloaded from bits 11..0 of the word read. With the mode flag at 0 the address is kept. With opcode 7 there is no read.
- R6: An `exec_done` pulse returns the sequencer to step 0 on the next clock.
- R7: The interrupt-pending flag is set when interrupt enable is 1 and either device flag is 1, but only at step 3 or later. Requests seen during steps 0 to 2 are ignored.
- R8: With an interrupt pending, step 0 clears the memory address and copies the program counter to the temporary register. Step 1 raises the write strobe with that saved value on the write data and clears the program counter.
- R9: With an interrupt pending, step 2 pulses `ien_clr`, increments the program counter to 1, clears the pending flag and returns the counter to step 0. The next fetch reads address 1.
- R10: Once `halt` has been seen high at a clock edge, the counter, the registers and both strobes stay frozen until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rdata | input | 16 | Memory read data at `mem_addr` |
| exec_done | input | 1 | Execution unit finished; return to step 0 |
| ien | input | 1 | Interrupt enable |
| fgi | input | 1 | Input device ready flag |
| fgo | input | 1 | Output device ready flag |
| halt | input | 1 | Halt request, sticky until reset |
| mem_addr | output | 12 | Memory address register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data (temporary register) |
| ien_clr | output | 1 | Request to clear interrupt enable |
| pc_q | output | 12 | Program counter |
| ir_q | output | 16 | Instruction register |
| t_state | output | 16 | One-hot timing states |
| d_dec | output | 8 | One-hot opcode decode |
| i_flag | output | 1 | Addressing-mode flag |
| r_flag | output | 1 | Interrupt-pending flag |

## Verification
The bench builds the block with its default parameters: a 12-bit address, a 16-bit word, a 3-bit opcode and a 4-bit step counter. With these settings all 4096 words can be reached, so an indirect pointer may land anywhere. Every one of the eight opcodes appears in the random instruction stream, together with both settings of the mode flag. Memory-reference instructions reach step 4. This leaves room for interrupts to be raised after long fetch sequences, for the saved return address to overwrite the word at location 0, and for fetching to resume at address 1.

// File: rtl/isc_seq.sv
module isc_seq #(
  parameter int AW  = 12,
  parameter int DW  = 16,
  parameter int OPW = 3,
  parameter int SCW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DW-1:0]      mem_rdata,
  input  logic               exec_done,
  input  logic               ien,
  input  logic               fgi,
  input  logic               fgo,
  input  logic               halt,
  output logic [AW-1:0]      mem_addr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [DW-1:0]      mem_wdata,
  output logic               ien_clr,
  output logic [AW-1:0]      pc_q,
  output logic [DW-1:0]      ir_q,
  output logic [(1<<SCW)-1:0] t_state,
  output logic [(1<<OPW)-1:0] d_dec,
  output logic               i_flag,
  output logic               r_flag
);
  localparam int NT = 1 << SCW;
  localparam int ND = 1 << OPW;

  logic [SCW-1:0] sc;
  logic [AW-1:0]  ar, pc;
  logic [DW-1:0]  ir, tr;
  logic           i_q, r_q, halt_q;

  wire run   = !halt_q;
  wire t0    = t_state[0];
  wire t1    = t_state[1];
  wire t2    = t_state[2];
  wire t3    = t_state[3];
  wire d7    = d_dec[ND-1];
  wire fetch = t0 | t1 | t2;
  wire irq   = ien & (fgi | fgo);
  wire ind   = t3 & !d7 & i_q;
  wire sc_clr = exec_done | (r_q & t2);

  assign t_state   = {{(NT-1){1'b0}}, 1'b1} << sc;
  assign d_dec     = {{(ND-1){1'b0}}, 1'b1} << ir[DW-2 -: OPW];
  assign mem_addr  = ar;
  assign mem_wdata = tr;
  assign mem_rd    = run & ((!r_q & t1) | ind);
  assign mem_wr    = run & r_q & t1;
  assign ien_clr   = run & r_q & t2;
  assign pc_q      = pc;
  assign ir_q      = ir;
  assign i_flag    = i_q;
  assign r_flag    = r_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc <= '0; ar <= '0; pc <= '0; ir <= '0; tr <= '0;
      i_q <= 1'b0; r_q <= 1'b0; halt_q <= 1'b0;
    end else begin
      halt_q <= halt_q | halt;
      if (run) begin
        sc <= sc_clr ? '0 : sc + {{(SCW-1){1'b0}}, 1'b1};
        if (r_q & t2)          r_q <= 1'b0;
        else if (!fetch & irq) r_q <= 1'b1;
        if (r_q) begin
          if (t0) begin ar <= '0; tr <= {{(DW-AW){1'b0}}, pc}; end
          if (t1) pc <= '0;
          if (t2) pc <= pc + {{(AW-1){1'b0}}, 1'b1};
        end else begin
          if (t0) ar <= pc;
          if (t1) begin ir <= mem_rdata; pc <= pc + {{(AW-1){1'b0}}, 1'b1}; end
          if (t2) begin ar <= ir[AW-1:0]; i_q <= ir[DW-1]; end
        end
        if (ind) ar <= mem_rdata[AW-1:0];
      end
    end
  end
endmodule

module isc_seq_chk #(
  parameter int AW  = 12,
  parameter int SCW = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                halted,
  input logic                exec_done,
  input logic [(1<<SCW)-1:0] t_state,
  input logic                r_flag,
  input logic [AW-1:0]       pc_q,
  input logic                mem_rd,
  input logic                mem_wr,
  input logic [AW-1:0]       mem_addr
);
  AST_FETCH_PC_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_flag && t_state[1] && !halted) |=> pc_q == $past(pc_q) + {{(AW-1){1'b0}}, 1'b1}); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !mem_wr); // R3
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_done && !halted) |=> t_state[0]); // R6
  AST_NO_IRQ_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_flag && (t_state[0] || t_state[1] || t_state[2])) |=> !r_flag); // R7
  AST_SAVE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_addr == '0); // R8
  AST_INT_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (r_flag && t_state[2] && !halted) |=> (pc_q == {{(AW-1){1'b0}}, 1'b1} && !r_flag && t_state[0])); // R9
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(pc_q) && $stable(t_state) && $stable(mem_addr))); // R10
endmodule

bind isc_seq isc_seq_chk #(.AW(AW), .SCW(SCW)) chk_i (
  .clk(clk), .rst_n(rst_n), .halted(halt_q), .exec_done(exec_done),
  .t_state(t_state), .r_flag(r_flag), .pc_q(pc_q), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .mem_addr(mem_addr)
);

// File: tb/isc_seq_tb.sv
module isc_seq_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_rdata;
  logic        exec_done = 1'b0, ien = 1'b0, fgi = 1'b0, fgo = 1'b0, halt = 1'b0;
  logic [11:0] mem_addr, pc_q;
  logic        mem_rd, mem_wr, ien_clr, i_flag, r_flag;
  logic [15:0] mem_wdata, ir_q, t_state;
  logic [7:0]  d_dec;

  logic [15:0] mem [4096];
  int checks = 0, failures = 0;
  logic [11:0] exp_pc = '0;

  always #(CLK_P/2) clk = ~clk;
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

  isc_seq dut_i (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .exec_done(exec_done),
    .ien(ien), .fgi(fgi), .fgo(fgo), .halt(halt), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .ien_clr(ien_clr),
    .pc_q(pc_q), .ir_q(ir_q), .t_state(t_state), .d_dec(d_dec),
    .i_flag(i_flag), .r_flag(r_flag)
  );

  function automatic logic [15:0] step_hot(input int n);
    return 16'(1) << n;
  endfunction

  function automatic logic [7:0] op_hot(input logic [15:0] ins);
    return 8'(1) << ins[14:12];
  endfunction

  function automatic logic [11:0] eff_addr(input logic [15:0] ins, input logic [15:0] ptr);
    return (ins[14:12] != 3'd7 && ins[15]) ? ptr[11:0] : ins[11:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run_instr(input int mode, output bit got_r);
    logic [15:0] ins;
    logic [11:0] ea;
    bit ie, fi, fo, er, noise;
    chk(t_state == step_hot(0), "R2 step0", t_state, step_hot(0));
    noise = (mode == 2) || ($urandom % 2 == 1);
    ien = noise; fgi = noise; fgo = noise;
    @(negedge clk);
    chk(mem_addr == exp_pc, "R3 addr from pc", mem_addr, exp_pc);
    chk(mem_rd == 1'b1, "R3 fetch read", mem_rd, 1);
    ins = mem[exp_pc];
    @(negedge clk);
    chk(ir_q == ins, "R3 ir load", ir_q, ins);
    chk(pc_q == exp_pc + 12'd1, "R3 pc inc", pc_q, exp_pc + 12'd1);
    chk(t_state == step_hot(2), "R2 step2", t_state, step_hot(2));
    exp_pc = exp_pc + 12'd1;
    ien = 0; fgi = 0; fgo = 0;
    @(negedge clk);
    chk(mem_addr == ins[11:0], "R4 addr field", mem_addr, ins[11:0]);
    chk(i_flag == ins[15], "R4 mode flag", i_flag, ins[15]);
    chk(d_dec == op_hot(ins), "R4 decode", d_dec, op_hot(ins));
    chk(r_flag == 1'b0, "R7 fetch request ignored", r_flag, 0);
    chk(mem_rd == (ins[14:12] != 3'd7 && ins[15]), "R5 indirect read", mem_rd, (ins[14:12] != 3'd7 && ins[15]));
    ea = eff_addr(ins, mem[ins[11:0]]);
    if (mode == 1)      begin ie = 1; fi = 1; fo = 0; end
    else if (mode == 2) begin ie = 0; fi = 1; fo = 1; end
    else begin ie = ($urandom % 3 == 0); fi = $urandom % 2; fo = $urandom % 2; end
    er = ie & (fi | fo);
    ien = ie; fgi = fi; fgo = fo;
    if (ins[14:12] == 3'd7) exec_done = 1'b1;
    @(negedge clk);
    ien = 0; fgi = 0; fgo = 0;
    if (ins[14:12] == 3'd7) begin
      exec_done = 1'b0;
      chk(t_state == step_hot(0), "R6 done at step3", t_state, step_hot(0));
      chk(r_flag == er, "R7 request at step3", r_flag, er);
    end else begin
      chk(t_state == step_hot(4), "R2 step4", t_state, step_hot(4));
      chk(mem_addr == ea, "R5 effective address", mem_addr, ea);
      chk(r_flag == er, "R7 request at step3", r_flag, er);
      exec_done = 1'b1;
      @(negedge clk);
      exec_done = 1'b0;
      chk(t_state == step_hot(0), "R6 done at step4", t_state, step_hot(0));
    end
    got_r = er;
  endtask

  task automatic int_cycle();
    chk(r_flag == 1'b1, "R8 pending at step0", r_flag, 1);
    @(negedge clk);
    chk(mem_addr == 12'd0, "R8 addr cleared", mem_addr, 0);
    chk(mem_wr == 1'b1, "R8 write strobe", mem_wr, 1);
    chk(mem_wdata == {4'd0, exp_pc}, "R8 saved pc", mem_wdata, exp_pc);
    @(negedge clk);
    chk(pc_q == 12'd0, "R8 pc cleared", pc_q, 0);
    chk(mem[0] == {4'd0, exp_pc}, "R8 return address stored", mem[0], exp_pc);
    chk(ien_clr == 1'b1, "R9 enable clear", ien_clr, 1);
    @(negedge clk);
    chk(pc_q == 12'd1, "R9 vector", pc_q, 1);
    chk(r_flag == 1'b0, "R9 pending cleared", r_flag, 0);
    chk(t_state == step_hot(0), "R9 back to step0", t_state, step_hot(0));
    exp_pc = 12'd1;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    bit gr;
    logic [11:0] hpc;
    void'($urandom(32'd2718));
    for (int k = 0; k < 4096; k++) mem[k] = 16'($urandom);
    mem[0] = 16'h2123;
    mem[1] = 16'h9200;
    mem[2] = 16'h7400;
    mem[3] = 16'hF080;
    mem[12'h200] = 16'h0ABC;
    repeat (3) @(negedge clk);
    chk(t_state == step_hot(0), "R1 reset step", t_state, step_hot(0));
    chk(pc_q == 12'd0, "R1 reset pc", pc_q, 0);
    chk(r_flag == 1'b0 && i_flag == 1'b0, "R1 reset flags", {r_flag, i_flag}, 0);
    chk(mem_wr == 1'b0 && mem_rd == 1'b0, "R1 reset strobes", {mem_rd, mem_wr}, 0);
    rst_n = 1'b1;
    for (int n = 0; n < 4; n++) run_instr(2, gr);
    run_instr(1, gr);
    chk(gr == 1'b1, "R7 directed request", gr, 1);
    int_cycle();
    for (int n = 0; n < 60; n++) begin
      run_instr(0, gr);
      if (gr) int_cycle();
    end
    chk(t_state == step_hot(0), "R10 pre-halt step", t_state, step_hot(0));
    halt = 1'b1;
    @(negedge clk);
    halt = 1'b0;
    hpc = pc_q;
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      chk(t_state == step_hot(1), "R10 step frozen", t_state, step_hot(1));
      chk(pc_q == hpc, "R10 pc frozen", pc_q, hpc);
      chk(mem_rd == 1'b0, "R10 no read", mem_rd, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule